// File: doc/BRIEF.md
# Converter Round-Trip Latency Counter

This block measures the fixed latency of a converter-to-FPGA receive path. It raises a test pulse that leaves the FPGA toward an ADC input. It then counts frame-clock cycles until that pulse shows up again in the parallel sample stream coming back over the serial link. The result is the combined latency of the converter and the link, in frame-clock cycles.

A measurement can only begin once the receive link reports it is up and the sample stream is flagged valid. The return of the pulse is taken from the sign bits of the samples. In each cycle, the block ORs together the most-significant bit of every sample. It treats a change of that OR from low to high as the stop event. This means a sample that is already high when the pulse is launched does not end the count early.

If the link drops during a measurement, the measurement is abandoned. If the count saturates before the pulse returns, that is flagged as an overflow. Repeating the measurement across resets should give counts that agree to within one or two link-clock periods. With a 2:1 frame-to-link clock ratio, that is two to four counts.

Top module: `rtrip_lat_meter`

## Requirements
- R1: While rst_ni is low, and after its release, pulse_o, done_o and ovf_o are 0 and count_o is 0.
- R2: start_i is accepted only in a cycle where link_up_i and strm_valid_i are both 1. Otherwise pulse_o stays 0.
- R3: After an accepted start_i, pulse_o is 1 from the next clock edge. Call the first cycle with pulse_o high cycle 0. If the stop event appears in cycle k, count_o captures k.
- R4: Sample i occupies samp_i[i*SAMP_W +: SAMP_W]. The stop input is the OR over all samples of bit SAMP_W-1, and all lower sample bits have no effect.
- R5: The stop event needs that OR to be 0 in the previous cycle and 1 in the current cycle. An OR that is already high when the pulse starts does not stop the count.
- R6: On the edge that ends a measurement, pulse_o falls and done_o rises in the same cycle, and count_o shows the result.
- R7: The counter is CNT_W bits wide and stops at 2^CNT_W-1. If the count is at that maximum and no stop event arrives, the measurement ends with count_o at all-ones and ovf_o = 1.
- R8: start_i while pulse_o is high has no effect on the measurement or its result.
- R9: An accepted start_i while done_o is 1 clears done_o, ovf_o and count_o and starts a new measurement.
- R10: If link_up_i or strm_valid_i is 0 while pulse_o is high, the next edge lowers pulse_o, done_o stays 0 and count_o stays 0.
- R11: While done_o is 1 and no start_i is accepted, done_o, ovf_o and count_o hold their values whatever the samples do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Frame clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Receive link established |
| strm_valid_i | input | 1 | Received sample stream valid |
| samp_i | input | NUM_SAMP*SAMP_W | Received samples, sample i at bits i*SAMP_W upward |
| start_i | input | 1 | Measurement request |
| pulse_o | output | 1 | Test pulse toward the converter input |
| count_o | output | CNT_W | Captured latency in frame-clock cycles |
| done_o | output | 1 | Measurement finished, result valid |
| ovf_o | output | 1 | Count saturated without a stop event |

## Verification
The bench builds the block with NUM_SAMP=4, SAMP_W=8 and CNT_W=8. The narrow counter brings saturation at 255 within a few hundred cycles, so the overflow path and the boundary where a stop arrives just before it are exercised directly rather than left to the 16-bit default. Four narrow samples keep random lower-bit noise dense. They also let every sample position carry the returning edge across the random trials, next to directed cases for residual high sign bits, aborts, stray starts and re-arming.

// File: rtl/rtrip_pkg.sv
package rtrip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_DONE = 2'd2
  } meas_state_e;
endpackage

// File: rtl/rtrip_msb_edge.sv
module rtrip_msb_edge #(
  parameter int NUM_SAMP = 8,
  parameter int SAMP_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SAMP*SAMP_W-1:0] samp_i,
  output logic                       stop_o
);
  localparam logic [SAMP_W-1:0] HALF_SCALE = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [NUM_SAMP-1:0] msb;
  logic                any_hi;
  logic                any_hi_q;

  // unsigned compare against half scale equals the top bit
  for (genvar g = 0; g < NUM_SAMP; g++) begin : g_msb
    assign msb[g] = (samp_i[g*SAMP_W +: SAMP_W] >= HALF_SCALE);
  end

  assign any_hi = |msb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_hi_q <= 1'b0;
    else         any_hi_q <= any_hi;
  end

  assign stop_o = any_hi & ~any_hi_q;

  p_stop_after_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

// File: rtl/rtrip_sat_cnt.sv
module rtrip_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             max_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign max_o = (cnt_q == CNT_MAX);

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_o && !clr_i) |=> max_o);
  p_clr_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/rtrip_meas_ctrl.sv
module rtrip_meas_ctrl
  import rtrip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic cnt_max_i,
  output logic clr_o,
  output logic cnt_en_o,
  output logic capture_o,
  output logic pulse_o,
  output logic done_o,
  output logic ovf_o
);
  meas_state_e state_q, state_d;
  logic        ovf_q, ovf_d;
  logic        accept;

  assign accept = start_i && ready_i && (state_q != ST_MEAS);

  always_comb begin
    state_d   = state_q;
    ovf_d     = ovf_q;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d = ST_MEAS;
          ovf_d   = 1'b0;
        end
      end
      ST_MEAS: begin
        if (!ready_i) begin
          state_d = ST_IDLE;
        end else if (stop_i) begin
          state_d   = ST_DONE;
          capture_o = 1'b1;
        end else if (cnt_max_i) begin
          state_d   = ST_DONE;
          capture_o = 1'b1;
          ovf_d     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
    end
  end

  assign clr_o    = accept;
  assign cnt_en_o = (state_q == ST_MEAS);
  assign pulse_o  = (state_q == ST_MEAS);
  assign done_o   = (state_q == ST_DONE);
  assign ovf_o    = ovf_q;

  p_no_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !ready_i) |=> !pulse_o);
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !ready_i) |=> (!pulse_o && !done_o));
  p_pulse_done_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_o && done_o));
  p_ovf_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> done_o);
  p_end_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && ready_i && stop_i) |=> (done_o && !pulse_o));
endmodule

// File: rtl/rtrip_lat_meter.sv
module rtrip_lat_meter #(
  parameter int NUM_SAMP = 8,
  parameter int SAMP_W   = 16,
  parameter int CNT_W    = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       link_up_i,
  input  logic                       strm_valid_i,
  input  logic [NUM_SAMP*SAMP_W-1:0] samp_i,
  input  logic                       start_i,
  output logic                       pulse_o,
  output logic [CNT_W-1:0]           count_o,
  output logic                       done_o,
  output logic                       ovf_o
);
  logic             ready;
  logic             stop;
  logic             clr, cnt_en, capture, cnt_max;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] count_q;

  assign ready = link_up_i & strm_valid_i;

  rtrip_msb_edge #(.NUM_SAMP(NUM_SAMP), .SAMP_W(SAMP_W)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (samp_i),
    .stop_o (stop)
  );

  rtrip_sat_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (cnt_en),
    .cnt_o  (cnt),
    .max_o  (cnt_max)
  );

  rtrip_meas_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready),
    .start_i   (start_i),
    .stop_i    (stop),
    .cnt_max_i (cnt_max),
    .clr_o     (clr),
    .cnt_en_o  (cnt_en),
    .capture_o (capture),
    .pulse_o   (pulse_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clr)     count_q <= '0;
    else if (capture) count_q <= cnt;
  end

  assign count_o = count_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(count_o) && $stable(ovf_o)));
  p_ovf_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == {CNT_W{1'b1}}));
  p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i && ready) |=> (pulse_o && !ovf_o && count_o == '0));
endmodule

// File: tb/test_rtrip_lat_meter.sv
module test_rtrip_lat_meter;
  localparam int NS   = 4;
  localparam int SW   = 8;
  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              link_up, strm_valid, start;
  logic [NS*SW-1:0]  samp;
  logic              pulse, done, ovf;
  logic [CW-1:0]     count;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtrip_lat_meter #(.NUM_SAMP(NS), .SAMP_W(SW), .CNT_W(CW)) i_rtrip_lat_meter (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .strm_valid_i(strm_valid),
    .samp_i(samp), .start_i(start), .pulse_o(pulse), .count_o(count),
    .done_o(done), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int k);
    return (k > CMAX) ? CMAX : k;
  endfunction

  // msb_mask bit i sets sign bit of sample i; low bits from noise
  function automatic logic [NS*SW-1:0] mk_samp(input logic [NS-1:0] msb_mask, input bit lo_ones);
    logic [NS*SW-1:0] v;
    for (int i = 0; i < NS; i++) begin
      logic [SW-1:0] s;
      s = lo_ones ? {1'b0, {(SW-1){1'b1}}} : SW'($urandom) & {1'b0, {(SW-1){1'b1}}};
      s[SW-1] = msb_mask[i];
      v[i*SW +: SW] = s;
    end
    return v;
  endfunction

  task automatic run_meas(input int k, input int idx, input bit stray, input bit lo_ones);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(pulse === 1'b1, "R3 pulse rise", pulse, 1);
    chk(done === 1'b0 && count === '0 && ovf === 1'b0, "R9 cleared on start", count, 0);
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      start = stray && (j == 2);
      samp  = mk_samp('0, lo_ones);
    end
    start = 1'b0;
    chk(pulse === 1'b1, "R3 pulse held", pulse, 1);
    samp = mk_samp(NS'(1) << idx, lo_ones);
    @(negedge clk);
    chk(done === 1'b1 && pulse === 1'b0, "R6 end edge", done, 1);
    chk(int'(count) == exp_cnt(k) && ovf === 1'b0, stray ? "R8 stray start" : "R3 count",
        count, exp_cnt(k));
    samp = mk_samp('0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; link_up = 1'b0; strm_valid = 1'b0; start = 1'b0; samp = '0;
    repeat (3) @(negedge clk);
    chk(pulse === 0 && done === 0 && ovf === 0 && count === '0, "R1 in reset", count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pulse === 0 && done === 0 && ovf === 0 && count === '0, "R1 after reset", count, 0);

    // R2: no arm without link or valid
    start = 1'b1; strm_valid = 1'b1;
    @(negedge clk) chk(pulse === 1'b0, "R2 link down", pulse, 0);
    link_up = 1'b1; strm_valid = 1'b0;
    @(negedge clk) chk(pulse === 1'b0, "R2 valid low", pulse, 0);
    start = 1'b0; strm_valid = 1'b1;
    @(negedge clk);

    run_meas(0, 0, 0, 0);
    run_meas(7, 3, 0, 1);   // R4: lower bits all ones never stop
    run_meas(9, 1, 1, 0);   // R8

    // R11: hold result while samples toggle
    for (int j = 0; j < 5; j++) begin
      @(negedge clk) samp = mk_samp(NS'(j), 1'b0);
    end
    @(negedge clk);
    chk(done === 1'b1 && int'(count) == 9 && ovf === 1'b0, "R11 hold", count, 9);
    samp = '0;
    @(negedge clk);

    // R5: residual high sign bit at launch
    samp = mk_samp('1, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) samp = mk_samp('0, 1'b0);
    chk(pulse === 1'b1 && done === 1'b0, "R5 no early stop", done, 0);
    repeat (4) @(negedge clk);
    samp = mk_samp(4'b0100, 1'b0);
    @(negedge clk);
    chk(done === 1'b1 && int'(count) == 5, "R5 count", count, 5);
    samp = '0;

    // random trials
    for (int t = 0; t < 30; t++) begin
      int k;
      k = $urandom_range(0, 60);
      run_meas(k, $urandom_range(0, NS - 1), 0, 0);
    end

    // R7: just before saturation, then saturation
    run_meas(CMAX, 2, 0, 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (CMAX) @(negedge clk) samp = mk_samp('0, 1'b0);
    chk(pulse === 1'b1 && done === 1'b0, "R7 not yet", done, 0);
    @(negedge clk);
    chk(done === 1'b1 && ovf === 1'b1 && pulse === 1'b0, "R7 ovf flag", ovf, 1);
    chk(int'(count) == CMAX, "R7 saturated count", count, CMAX);
    run_meas(3, 0, 0, 0);   // R9 re-arm clears ovf

    // R10: abort by link or valid loss
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    link_up = 1'b0;
    @(negedge clk);
    chk(pulse === 0 && done === 0 && count === '0, "R10 link abort", pulse, 0);
    link_up = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) strm_valid = 1'b0;
    @(negedge clk);
    chk(pulse === 0 && done === 0 && count === '0, "R10 valid abort", pulse, 0);
    strm_valid = 1'b1;
    samp = mk_samp('1, 1'b0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done stays low", done, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule